// File: doc/BRIEF.md
# Word-Framed SPI Region Target

This block is an SPI mode 0 target. Its address space is split into a handful of numbered regions. A host opens a frame by pulling chip select low. It first shifts in a 16-bit region number, then a command word: bit 15 picks write (1) or read (0), and bits 14:0 give the payload length in 16-bit words. The payload words follow. While the host shifts in those first two words, the target answers with a fixed signature word and then its current event-flag word. In a read, the region's words follow in the payload slots.

Region 0 is a status view. It is built from a timer value and an event-info word that the local side supplies, and the target captures both at the moment the command word completes. Regions 1 to 6 are data stores of `REGION_WORDS` words each. The local side fills and drains them through a simple word port. The local side raises event flags with a one-cycle mask pulse, and `irq_n` sits low while any flag is set. When the host finishes reading a data region, the flag tied to that region is cleared. Raising chip select before all the requested words have moved abandons the frame.

Top module: `spi_region_target`

## Requirements
- R1: Word 0 of a frame (MSB first) is the region number. Word 1 carries the command in bit 15 (1 = write, 0 = read) and the payload length in bits 14:0, counted in 16-bit words. Payload words follow from word 2 onward.
- R2: During word 0 of every frame, MISO carries 0x1122. During word 1, it carries the event-flag word. MISO is low whenever chip select is high. MISO changes after SCLK falls and is read by the host on SCLK rising.
- R3: A read of region 0 returns these payload words in order: timer[31:16], timer[15:0], info[31:16], info[15:0]. Both values are captured when the command word completes. Payload words from index 4 onward read as zero.
- R4: A read of regions 1 to 6 returns the stored words from index 0 for the requested length. Payload slots past the length read as zero.
- R5: A write to regions 1 to 6 stores payload word k at index k for k below the length. The local port writes a word on `loc_we` and reads any word combinationally through `loc_rdata`.
- R6: Payload words past `REGION_WORDS` are dropped on a write and leave other regions untouched. On a read they return zero.
- R7: Writes to region 0 or to regions above 6 change no stored word and no flag.
- R8: `loc_set_flags` ORs its mask into the flag word. The flag bits are: bit 0 TX confirm, bit 1 RX data, bit 3 register reply, bit 4 RX parameters. `irq_n` is low exactly while the flag word is non-zero. After reset, flags are zero and `irq_n` is high.
- R9: When chip select rises after a read has moved every requested payload word, flags are cleared by region: region 3 clears bit 0, region 5 clears bit 1, region 6 clears bit 3, region 4 clears bit 4. A read of region 0 clears nothing. A set in the same cycle wins over the clear.
- R10: Raising chip select before the payload is complete, even in the middle of a word, clears no flag. The next frame is parsed from word 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SPI |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | Host-to-target data |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Target-to-host data |
| irq_n | output | 1 | Low while any event flag is set |
| loc_we | input | 1 | Local write strobe |
| loc_region | input | 3 | Local region number (1 to 6) |
| loc_idx | input | $clog2(REGION_WORDS) | Local word index |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data |
| loc_set_flags | input | 16 | One-cycle flag set mask |
| ts_value | input | 32 | Timer value shown in region 0 |
| ev_info | input | 32 | Event-info value shown in region 0 |

## Verification
Directed frames cover the status region, full data-region reads, reads longer than capacity, writes that overrun a region, and writes to region 0 or region 7. Together they separate the signature, flag and payload slots, and show that zero fill, dropped words and ignored regions land where they should. Aborts after a whole word and in the middle of a word are compared with completed reads of the same region, so a premature flag clear or a stale parser state shows up. Random frames over all regions, lengths and directions are checked against a bench memory model. The local port then reads every region back to confirm the final stored contents.

// File: rtl/spi_rgn_pkg.sv
package spi_rgn_pkg;
  localparam logic [15:0] SIG_WORD  = 16'h1122;
  localparam logic [15:0] EVT_TXCFM = 16'h0001;
  localparam logic [15:0] EVT_RXDAT = 16'h0002;
  localparam logic [15:0] EVT_REGRS = 16'h0008;
  localparam logic [15:0] EVT_RXPAR = 16'h0010;

  // regions 1..6 hold storage
  function automatic logic is_data_region(input logic [15:0] rgn);
    return (rgn >= 16'd1) && (rgn <= 16'd6);
  endfunction

  // flag bits released by a completed read of a region
  function automatic logic [15:0] release_mask(input logic [15:0] rgn);
    case (rgn)
      16'd3:   return EVT_TXCFM;
      16'd4:   return EVT_RXPAR;
      16'd5:   return EVT_RXDAT;
      16'd6:   return EVT_REGRS;
      default: return 16'h0000;
    endcase
  endfunction

  // status view word for payload slot 0..3
  function automatic logic [15:0] status_word(input logic [31:0] ts, input logic [31:0] info,
                                              input logic [1:0] slot);
    case (slot)
      2'd0:    return ts[31:16];
      2'd1:    return ts[15:0];
      2'd2:    return info[31:16];
      default: return info[15:0];
    endcase
  endfunction
endpackage

// File: rtl/spi_rgn_shifter.sv
module spi_rgn_shifter #(
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           mosi,
  input  logic           cs_n,
  input  logic [15:0]    tx_word,
  output logic           miso,
  output logic           start_evt,
  output logic           end_evt,
  output logic           word_evt,
  output logic [15:0]    rx_word,
  output logic [WCW-1:0] word_cnt
);
  import spi_rgn_pkg::*;

  logic [1:0]  cs_sy, sck_sy, mo_sy;
  logic        cs_q, sck_q, active, sck_rise, sck_fall;
  logic [3:0]  bit_cnt;
  logic [15:0] rx_sh, tx_sh;

  assign active    = ~cs_sy[1];
  assign start_evt = cs_q & ~cs_sy[1];
  assign end_evt   = ~cs_q & cs_sy[1];
  assign sck_rise  = active & sck_sy[1] & ~sck_q;
  assign sck_fall  = active & ~sck_sy[1] & sck_q;
  assign word_evt  = sck_rise & ~start_evt & (bit_cnt == 4'd15);
  assign rx_word   = {rx_sh[14:0], mo_sy[1]};
  assign miso      = active & tx_sh[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= 2'b11;
      cs_q   <= 1'b1;
      sck_sy <= 2'b00;
      sck_q  <= 1'b0;
      mo_sy  <= 2'b00;
    end else begin
      cs_sy  <= {cs_sy[0], cs_n};
      cs_q   <= cs_sy[1];
      sck_sy <= {sck_sy[0], sclk};
      sck_q  <= sck_sy[1];
      mo_sy  <= {mo_sy[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
    end else if (start_evt) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
      rx_sh    <= '0;
      tx_sh    <= SIG_WORD;
    end else if (end_evt) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
    end else begin
      if (sck_rise) begin
        rx_sh   <= rx_word;
        bit_cnt <= bit_cnt + 4'd1;
        if (word_evt && (word_cnt != '1)) word_cnt <= word_cnt + 1'b1;
      end
      if (sck_fall) begin
        if (bit_cnt == 4'd0) tx_sh <= tx_word;
        else                 tx_sh <= {tx_sh[14:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_rgn_store.sv
module spi_rgn_store #(
  parameter int RW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [2:0]    host_region,
  input  logic [AW-1:0] host_idx,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  input  logic          loc_we,
  input  logic [2:0]    loc_region,
  input  logic [AW-1:0] loc_idx,
  input  logic [15:0]   loc_wdata,
  output logic [15:0]   loc_rdata
);
  localparam int NDR = 6;

  logic [15:0] mem [NDR][RW];

  function automatic logic ok(input logic [2:0] r);
    return (r >= 3'd1) && (r <= 3'd6);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NDR; r++)
        for (int i = 0; i < RW; i++)
          mem[r][i] <= '0;
    end else if (host_we) begin
      mem[host_region - 3'd1][host_idx] <= host_wdata;
    end else if (loc_we && ok(loc_region)) begin
      mem[loc_region - 3'd1][loc_idx] <= loc_wdata;
    end
  end

  assign host_rdata = ok(host_region) ? mem[host_region - 3'd1][host_idx] : '0;
  assign loc_rdata  = ok(loc_region)  ? mem[loc_region - 3'd1][loc_idx]   : '0;
endmodule

// File: rtl/spi_rgn_frame.sv
module spi_rgn_frame #(
  parameter int RW  = 8,
  parameter int AW  = 3,
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           end_evt,
  input  logic           word_evt,
  input  logic [15:0]    rx_word,
  input  logic [WCW-1:0] word_cnt,
  input  logic [31:0]    ts_value,
  input  logic [31:0]    ev_info,
  input  logic [15:0]    loc_set_flags,
  input  logic [15:0]    mem_rdata,
  output logic [15:0]    tx_word,
  output logic           host_we,
  output logic [2:0]     host_region,
  output logic [AW-1:0]  host_idx,
  output logic [15:0]   host_wdata,
  output logic [15:0]    flags,
  output logic           clr_evt
);
  import spi_rgn_pkg::*;

  logic [15:0]    rgn;
  logic           cmd_wr;
  logic [14:0]    len;
  logic [31:0]    ts_snap, info_snap;
  logic [WCW-1:0] p;
  logic           in_pay, in_len, in_cap;

  assign p      = word_cnt - WCW'(2);
  assign in_pay = word_cnt >= WCW'(2);
  assign in_len = in_pay && (p < WCW'(len));
  assign in_cap = is_data_region(rgn) && (p < WCW'(RW));

  assign host_region = rgn[2:0];
  assign host_idx    = p[AW-1:0];
  assign host_wdata  = rx_word;
  assign host_we     = word_evt && cmd_wr && in_len && in_cap;

  always_comb begin
    tx_word = '0;
    if (word_cnt == WCW'(1)) begin
      tx_word = flags;
    end else if (in_len && !cmd_wr) begin
      if (rgn == 16'd0) tx_word = (p < WCW'(4)) ? status_word(ts_snap, info_snap, p[1:0]) : '0;
      else if (in_cap)  tx_word = mem_rdata;
    end
  end

  assign clr_evt = end_evt && in_pay && !cmd_wr && (word_cnt >= WCW'(len) + WCW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn       <= '0;
      cmd_wr    <= 1'b0;
      len       <= '0;
      ts_snap   <= '0;
      info_snap <= '0;
      flags     <= '0;
    end else begin
      if (word_evt && word_cnt == WCW'(0)) rgn <= rx_word;
      if (word_evt && word_cnt == WCW'(1)) begin
        cmd_wr    <= rx_word[15];
        len       <= rx_word[14:0];
        ts_snap   <= ts_value;
        info_snap <= ev_info;
      end
      flags <= (flags & ~(clr_evt ? release_mask(rgn) : 16'h0000)) | loc_set_flags;
    end
  end
endmodule

// File: rtl/spi_region_target.sv
module spi_region_target #(
  parameter int REGION_WORDS = 8,
  parameter int WCW          = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            spi_sclk,
  input  logic                            spi_mosi,
  input  logic                            spi_cs_n,
  output logic                            spi_miso,
  output logic                            irq_n,
  input  logic                            loc_we,
  input  logic [2:0]                      loc_region,
  input  logic [$clog2(REGION_WORDS)-1:0] loc_idx,
  input  logic [15:0]                     loc_wdata,
  output logic [15:0]                     loc_rdata,
  input  logic [15:0]                     loc_set_flags,
  input  logic [31:0]                     ts_value,
  input  logic [31:0]                     ev_info
);
  localparam int AW = $clog2(REGION_WORDS);

  logic           start_evt, end_evt, word_evt, clr_evt, host_we;
  logic [15:0]    rx_word, tx_word, mem_rdata, flags, host_wdata;
  logic [WCW-1:0] word_cnt;
  logic [2:0]     host_region;
  logic [AW-1:0]  host_idx;

  spi_rgn_shifter #(.WCW(WCW)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .tx_word(tx_word), .miso(spi_miso), .start_evt(start_evt), .end_evt(end_evt),
    .word_evt(word_evt), .rx_word(rx_word), .word_cnt(word_cnt)
  );

  spi_rgn_frame #(.RW(REGION_WORDS), .AW(AW), .WCW(WCW)) u_frame (
    .clk(clk), .rst_n(rst_n), .end_evt(end_evt), .word_evt(word_evt),
    .rx_word(rx_word), .word_cnt(word_cnt), .ts_value(ts_value), .ev_info(ev_info),
    .loc_set_flags(loc_set_flags), .mem_rdata(mem_rdata), .tx_word(tx_word),
    .host_we(host_we), .host_region(host_region), .host_idx(host_idx),
    .host_wdata(host_wdata), .flags(flags), .clr_evt(clr_evt)
  );

  spi_rgn_store #(.RW(REGION_WORDS), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_region(host_region),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(mem_rdata),
    .loc_we(loc_we), .loc_region(loc_region), .loc_idx(loc_idx),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  assign irq_n = ~|flags;
endmodule

// File: rtl/spi_rgn_checker.sv
module spi_rgn_checker #(
  parameter int WCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_n,
  input logic           spi_miso,
  input logic [15:0]    loc_set_flags,
  input logic           end_evt,
  input logic           word_evt,
  input logic [WCW-1:0] word_cnt,
  input logic           clr_evt,
  input logic           host_we,
  input logic [2:0]     host_region
);
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_evt && word_cnt != '1) |=> word_cnt == $past(word_cnt) + 1'b1); // R1
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !spi_miso); // R2
  AST_HOST_WRITE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> (host_region >= 3'd1 && host_region <= 3'd6)); // R7
  AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_set_flags != 16'h0) |=> !irq_n); // R8
  AST_RELEASE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(clr_evt)); // R9
  AST_CLEAR_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |-> end_evt); // R10
  AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> word_cnt == '0); // R10
endmodule

bind spi_region_target spi_rgn_checker #(.WCW(WCW)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .spi_miso(spi_miso),
  .loc_set_flags(loc_set_flags), .end_evt(end_evt), .word_evt(word_evt),
  .word_cnt(word_cnt), .clr_evt(clr_evt), .host_we(host_we), .host_region(host_region)
);

// File: tb/test_spi_region_target.sv
`timescale 1ns/1ps
module test_spi_region_target;
  localparam int RW   = 8;
  localparam int AW   = $clog2(RW);
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, miso, irq_n;
  logic loc_we = 1'b0;
  logic [2:0] loc_region = 3'd1;
  logic [AW-1:0] loc_idx = '0;
  logic [15:0] loc_wdata = '0, loc_rdata, loc_set_flags = '0;
  logic [31:0] ts_value = 32'hA5A5_0001, ev_info = 32'h0000_0010;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] rsp [0:31];
  logic [15:0] txbuf [0:31];
  logic [15:0] mdl [1:6][0:RW-1];

  always #2.5 clk = ~clk;

  spi_region_target #(.REGION_WORDS(RW)) i_spi_region_target (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(miso), .irq_n(irq_n), .loc_we(loc_we), .loc_region(loc_region),
    .loc_idx(loc_idx), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .loc_set_flags(loc_set_flags), .ts_value(ts_value), .ev_info(ev_info)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [15:0] rg, input int k, input int len);
    if (k >= len) return 16'h0;
    if (rg == 0) begin
      if (k == 0) return ts_value[31:16];
      if (k == 1) return ts_value[15:0];
      if (k == 2) return ev_info[31:16];
      if (k == 3) return ev_info[15:0];
      return 16'h0;
    end
    if (rg >= 1 && rg <= 6 && k < RW) return mdl[rg][k];
    return 16'h0;
  endfunction

  task automatic spi_bits(input logic [15:0] tx, input int nb, output logic [15:0] rx);
    rx = '0;
    for (int i = 15; i > 15 - nb; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic do_frame(input logic [15:0] rg, input bit wr, input int len, input int nw);
    logic [15:0] w;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_bits(rg, 16, w); rsp[0] = w;
    spi_bits({wr, 15'(len)}, 16, w); rsp[1] = w;
    for (int i = 0; i < nw; i++) begin
      spi_bits(txbuf[i], 16, w); rsp[i+2] = w;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*HALF) @(negedge clk);
    if (wr && rg >= 1 && rg <= 6)
      for (int i = 0; i < nw; i++)
        if (i < len && i < RW) mdl[rg][i] = txbuf[i];
  endtask

  task automatic check_read(input string req, input logic [15:0] rg, input int len, input int nw);
    for (int k = 0; k < nw; k++) check(req, rsp[k+2], exp_rd(rg, k, len));
  endtask

  task automatic loc_write(input int rg, input int ix, input logic [15:0] d);
    @(negedge clk);
    loc_we = 1'b1; loc_region = 3'(rg); loc_idx = AW'(ix); loc_wdata = d;
    @(negedge clk);
    loc_we = 1'b0;
    mdl[rg][ix] = d;
  endtask

  task automatic loc_read(input int rg, input int ix, output logic [15:0] d);
    @(negedge clk);
    loc_region = 3'(rg); loc_idx = AW'(ix);
    #1 d = loc_rdata;
  endtask

  task automatic set_flags(input logic [15:0] m);
    @(negedge clk);
    loc_set_flags = m;
    @(negedge clk);
    loc_set_flags = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    for (int r = 1; r <= 6; r++) for (int i = 0; i < RW; i++) mdl[r][i] = '0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset irq_n", irq_n, 1);
    check("R2 idle miso", miso, 0);

    for (int r = 1; r <= 6; r++) for (int i = 0; i < RW; i++) loc_write(r, i, 16'($urandom));
    loc_read(4, 5, d); check("R5 local readback", d, mdl[4][5]);

    set_flags(16'h0002);
    check("R8 irq asserted", irq_n, 0);

    // status region, length beyond the four defined words
    do_frame(16'd0, 1'b0, 6, 6);
    check("R2 signature", rsp[0], 16'h1122);
    check("R2 flag word", rsp[1], 16'h0002);
    check_read("R3 status", 16'd0, 6, 6);
    check("R9 status read keeps flag", irq_n, 0);

    do_frame(16'd5, 1'b0, 3, 3);
    check_read("R4 data read", 16'd5, 3, 3);
    check("R9 rx data release", irq_n, 1);

    // aborts
    set_flags(16'h0001);
    do_frame(16'd3, 1'b0, 4, 3);
    check("R10 abort keeps flag", irq_n, 0);
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
    spi_bits(16'd3, 16, d); spi_bits(16'h0000, 5, d);
    repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (3*HALF) @(negedge clk);
    check("R10 mid-word abort keeps flag", irq_n, 0);
    do_frame(16'd0, 1'b0, 1, 1);
    check("R10 restart signature", rsp[0], 16'h1122);
    check("R10 restart flags", rsp[1], 16'h0001);
    check("R3 restart status", rsp[2], ts_value[31:16]);
    do_frame(16'd3, 1'b0, 2, 2);
    check_read("R4 tx confirm read", 16'd3, 2, 2);
    check("R9 tx confirm release", irq_n, 1);

    set_flags(16'h0018);
    do_frame(16'd6, 1'b0, 1, 1);
    do_frame(16'd0, 1'b0, 0, 0);
    check("R9 register release", rsp[1], 16'h0010);
    do_frame(16'd4, 1'b0, 0, 0);
    check("R9 rx param release", irq_n, 1);

    // writes
    for (int i = 0; i < 16; i++) txbuf[i] = 16'hC000 + 16'(i);
    do_frame(16'd2, 1'b1, 3, 3);
    loc_read(2, 2, d); check("R5 host write", d, 16'hC002);
    loc_read(2, 3, d); check("R5 beyond length kept", d, mdl[2][3]);
    for (int i = 0; i < 16; i++) txbuf[i] = 16'hB000 + 16'(i);
    do_frame(16'd1, 1'b1, RW+2, RW+2);
    loc_read(1, RW-1, d); check("R6 last word", d, 16'hB000 + 16'(RW-1));
    loc_read(2, 0, d); check("R6 neighbour intact", d, 16'hC000);
    do_frame(16'd1, 1'b0, RW+2, RW+2);
    check_read("R6 read past capacity", 16'd1, RW+2, RW+2);

    set_flags(16'h0000);
    do_frame(16'd0, 1'b1, 2, 2);
    do_frame(16'd7, 1'b1, 2, 2);
    do_frame(16'd0, 1'b0, 0, 0);
    check("R7 flags untouched", rsp[1], 16'h0000);
    for (int r = 1; r <= 6; r++) begin
      loc_read(r, 0, d); check("R7 no stray write", d, mdl[r][0]);
    end

    do_frame(16'd2, 1'b0, 1, 3);
    check_read("R4 past length zero", 16'd2, 1, 3);

    // random frames
    for (int n = 0; n < 18; n++) begin
      logic [15:0] rg;
      bit wr;
      int ln, nw;
      rg = 16'($urandom_range(0, 7));
      wr = 1'($urandom_range(0, 1));
      ln = $urandom_range(0, RW+2);
      nw = $urandom_range(0, RW+2);
      for (int i = 0; i < 16; i++) txbuf[i] = 16'($urandom);
      do_frame(rg, wr, ln, nw);
      check("R2 random signature", rsp[0], 16'h1122);
      if (!wr) check_read("R4 random read", rg, ln, nw);
    end
    for (int r = 1; r <= 6; r++) for (int i = 0; i < RW; i++) begin
      loc_read(r, i, d); check("R5 final contents", d, mdl[r][i]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule